// File: doc/BRIEF.md
# Zero-Turnaround Late-Write Synchronous SRAM

A single-port synchronous memory with a small parameterized array and a 32-bit data path split into four byte lanes. A command is sampled on a rising clock edge. The write data for that command arrives a fixed number of enabled edges later, and this delay equals the read latency. Because of that, reads and writes can alternate on every cycle and the data buses never need an idle turnaround cycle.

A static mode input selects one of two timings. In pipelined mode, read data is registered and write data is sampled two enabled edges after the command. In flow-through mode, read data appears combinationally right after the command edge and write data is sampled on the next enabled edge.

Pending write address and byte mask travel down a short delay pipe. A read that targets a word with a write still in that pipe returns the newer bytes. The mode input may change only while no command is in flight. The array itself has no reset.

Top module: `ltw_sram`

## Requirements
- R1: While `rst_n` is low, `dout_vld` is 0 and `dout` is all zeros.
- R2: A command is accepted on an enabled edge only when `ce_a_n`=0, `ce_b`=1, `ce_c_n`=0 and `ld_n`=0 all hold. Any other combination is a deselect: it writes nothing and produces no read data.
- R3: In pipelined mode (`ft_mode`=0), a read accepted on enabled edge n drives `dout` and `dout_vld`=1 after enabled edge n+1.
- R4: In flow-through mode (`ft_mode`=1), a read accepted on enabled edge n drives `dout` and `dout_vld`=1 directly after edge n.
- R5: The data for a write accepted on enabled edge n is taken from `din` on enabled edge n+2 in pipelined mode, or on edge n+1 in flow-through mode.
- R6: `be_n[i]`=0 writes `din[8i+7:8i]` into the same bits of the word; lanes whose `be_n` bit is 1 keep their old contents. Lane 0 is bits 7:0.
- R7: A write with `be_n`=4'hF leaves the array unchanged. No write command ever raises `dout_vld`.
- R8: A read returns the word as left by every write accepted before it, even when that write's data has not yet reached the array. This also covers a write to the same address on the immediately preceding edge.
- R9: When `clk_en_n`=1 on an edge, no command is accepted, `din` is not sampled, the pipeline and array hold, and `dout`/`dout_vld` keep their values.
- R10: Whenever `dout_vld` is 0, `dout` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control pipeline |
| ft_mode | input | 1 | 1 = flow-through timing, 0 = pipelined timing |
| clk_en_n | input | 1 | Active-low clock enable; high freezes the block |
| ce_a_n | input | 1 | Chip enable, active low |
| ce_b | input | 1 | Chip enable, active high |
| ce_c_n | input | 1 | Chip enable, active low |
| ld_n | input | 1 | Active-low load strobe for a new address and command |
| we_n | input | 1 | 0 = write, 1 = read |
| be_n | input | LANES | Active-low byte lane write enables |
| addr | input | AW | Word address |
| din | input | 8*LANES | Write data, sampled at the late-write edge |
| dout | output | 8*LANES | Read data, zero when not valid |
| dout_vld | output | 1 | Read data valid |

## Verification
The riskiest overlap is a write commit and a read of the same word landing on the same edge. This happens in pipelined mode when a read follows a write to that address on the next cycle, so the read output is captured on the edge where the write's data is first sampled. The bench provokes it directly, with full and partial byte masks, and again in a long random stream over a small address range. A freeze also falls between a write command and its data edge. A behavioural model keeps pending writes and reads in queues keyed by enabled-edge count, resolves each read against the writes committed by then, and compares `dout` and `dout_vld` on every cycle.

// File: rtl/ltw_sram.sv
module ltw_sram #(
  parameter int AW    = 4,
  parameter int LANES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ft_mode,
  input  logic                 clk_en_n,
  input  logic                 ce_a_n,
  input  logic                 ce_b,
  input  logic                 ce_c_n,
  input  logic                 ld_n,
  input  logic                 we_n,
  input  logic [LANES-1:0]     be_n,
  input  logic [AW-1:0]        addr,
  input  logic [8*LANES-1:0]   din,
  output logic [8*LANES-1:0]   dout,
  output logic                 dout_vld
);
  localparam int DW    = 8 * LANES;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  wire go  = ~clk_en_n;
  wire cmd = ~ce_a_n & ce_b & ~ce_c_n & ~ld_n;

  logic             s1_rd, s1_wr, s2_wr;
  logic [AW-1:0]    s1_addr, s2_addr;
  logic [LANES-1:0] s1_be, s2_be;
  logic [DW-1:0]    dq;
  logic             vq;

  wire             wr_now = ft_mode ? s1_wr   : s2_wr;
  wire [AW-1:0]    wr_a   = ft_mode ? s1_addr : s2_addr;
  wire [LANES-1:0] wr_be  = ft_mode ? s1_be   : s2_be;

  logic [DW-1:0] rd_word, fwd_word;
  assign rd_word = mem[s1_addr];

  always_comb begin
    for (int i = 0; i < LANES; i++)
      fwd_word[8*i +: 8] = (s2_wr && s2_be[i] && s2_addr == s1_addr) ?
                           din[8*i +: 8] : rd_word[8*i +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_rd   <= 1'b0;
      s1_wr   <= 1'b0;
      s2_wr   <= 1'b0;
      s1_addr <= '0;
      s2_addr <= '0;
      s1_be   <= '0;
      s2_be   <= '0;
      dq      <= '0;
      vq      <= 1'b0;
    end else if (go) begin
      s1_rd   <= cmd & we_n;
      s1_wr   <= cmd & ~we_n;
      s1_addr <= addr;
      s1_be   <= ~be_n;
      s2_wr   <= s1_wr;
      s2_addr <= s1_addr;
      s2_be   <= s1_be;
      dq      <= s1_rd ? fwd_word : '0;
      vq      <= s1_rd;
    end
  end

  always_ff @(posedge clk) begin
    if (go && wr_now)
      for (int i = 0; i < LANES; i++)
        if (wr_be[i]) mem[wr_a][8*i +: 8] <= din[8*i +: 8];
  end

  assign dout     = ft_mode ? (s1_rd ? rd_word : '0) : dq;
  assign dout_vld = ft_mode ? s1_rd : vq;
endmodule

module ltw_sram_chk #(
  parameter int AW    = 4,
  parameter int LANES = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ft_mode,
  input logic               clk_en_n,
  input logic               ce_a_n,
  input logic               ce_b,
  input logic               ce_c_n,
  input logic               ld_n,
  input logic               we_n,
  input logic [8*LANES-1:0] dout,
  input logic               dout_vld
);
  wire go     = ~clk_en_n;
  wire sel    = ~ce_a_n & ce_b & ~ce_c_n & ~ld_n;
  wire rd_cmd = go & sel & we_n;
  wire wr_cmd = go & sel & ~we_n;

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!dout_vld && dout == '0));

  // R10
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_vld |-> dout == '0);

  // R9
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_n |=> ($stable(dout) && $stable(dout_vld)));

  // R4
  ft_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ft_mode && rd_cmd) |=> dout_vld);

  // R3
  pipe_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ft_mode && rd_cmd) ##1 go |=> dout_vld);

  // R7
  ft_write_novld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ft_mode && wr_cmd) |=> !dout_vld);

  // R7
  pipe_write_novld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ft_mode && wr_cmd) ##1 go |=> !dout_vld);

  // R2
  deselect_novld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ft_mode && go && !sel) |=> !dout_vld);
endmodule

bind ltw_sram ltw_sram_chk #(.AW(AW), .LANES(LANES)) u_chk (.*);

// File: tb/test_ltw_sram.sv
module test_ltw_sram;
  localparam int AW = 4, LANES = 4, DW = 32, DEPTH = 16;

  logic clk = 1'b0;
  always #5ns clk = ~clk;

  logic rst_n = 1'b0, ft_mode = 1'b0, clk_en_n = 1'b1;
  logic ce_a_n = 1'b1, ce_b = 1'b0, ce_c_n = 1'b1, ld_n = 1'b1, we_n = 1'b1;
  logic [3:0] be_n = 4'hF;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic dout_vld;

  ltw_sram #(.AW(AW), .LANES(LANES)) i_ltw_sram (.*);

  int compared = 0, mismatched = 0;
  bit done = 1'b0;

  logic [DW-1:0] mem_m [DEPTH];
  int wq_a[$], wq_be[$], wq_due[$];
  int rq_a[$], rq_due[$];
  int nedge = 0;
  logic [DW-1:0] exp_d = '0;
  logic exp_v = 1'b0;

  task automatic compare(input string tag);
    compared++;
    if (dout !== exp_d || dout_vld !== exp_v) begin
      mismatched++;
      $display("FAIL %s: dout=%h vld=%b expected dout=%h vld=%b",
               tag, dout, dout_vld, exp_d, exp_v);
    end
  endtask

  task automatic model_edge();
    if (clk_en_n) return;
    nedge++;
    while (wq_due.size() > 0 && wq_due[0] == nedge) begin
      for (int i = 0; i < LANES; i++)
        if (wq_be[0][i]) mem_m[wq_a[0]][8*i +: 8] = din[8*i +: 8];
      void'(wq_a.pop_front()); void'(wq_be.pop_front()); void'(wq_due.pop_front());
    end
    if (!ce_a_n && ce_b && !ce_c_n && !ld_n) begin
      if (we_n) begin
        rq_a.push_back(int'(addr));
        rq_due.push_back(nedge + (ft_mode ? 0 : 1));
      end else begin
        wq_a.push_back(int'(addr));
        wq_be.push_back(int'(~be_n));
        wq_due.push_back(nedge + (ft_mode ? 1 : 2));
      end
    end
    if (rq_due.size() > 0 && rq_due[0] == nedge) begin
      exp_d = mem_m[rq_a[0]];
      exp_v = 1'b1;
      void'(rq_a.pop_front()); void'(rq_due.pop_front());
    end else begin
      exp_d = '0;
      exp_v = 1'b0;
    end
  endtask

  task automatic step(input logic ck_n, input logic [2:0] on, input logic ld,
                      input logic we, input logic [3:0] be, input int a,
                      input string tag);
    clk_en_n = ck_n;
    ce_a_n = ~on[0]; ce_b = on[1]; ce_c_n = ~on[2];
    ld_n = ld; we_n = we; be_n = be; addr = AW'(a);
    din = $urandom;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic rd(input int a, input string tag);
    step(1'b0, 3'b111, 1'b0, 1'b1, 4'hF, a, tag);
  endtask
  task automatic wr(input int a, input logic [3:0] be, input string tag);
    step(1'b0, 3'b111, 1'b0, 1'b0, be, a, tag);
  endtask
  task automatic idle(input int n, input string tag);
    for (int k = 0; k < n; k++) step(1'b0, 3'b000, 1'b1, 1'b1, 4'hF, 0, tag);
  endtask

  task automatic run_mode(input string lat_tag);
    rd(3, lat_tag); idle(3, lat_tag);
    rd(4, "R10"); wr(4, 4'h0, "R5"); rd(4, "R8"); idle(3, "R8");
    wr(5, 4'h0, "R8"); rd(5, "R8"); wr(5, 4'b1010, "R6"); rd(5, "R6"); idle(3, "R6");
    wr(6, 4'hF, "R7"); rd(6, "R7"); idle(3, "R7");
    for (int i = 0; i < 3; i++) step(1'b0, 3'b111 & ~(3'b1 << i), 1'b0, 1'b0, 4'h0, 7, "R2");
    step(1'b0, 3'b111, 1'b1, 1'b0, 4'h0, 7, "R2");
    step(1'b0, 3'b111, 1'b1, 1'b1, 4'hF, 7, "R2");
    idle(3, "R2"); rd(7, "R2"); idle(3, "R2");
    rd(8, "R9");
    for (int i = 0; i < 3; i++) step(1'b1, 3'b111, 1'b0, 1'b0, 4'h0, 8, "R9");
    idle(3, "R9"); rd(8, "R9");
    wr(9, 4'b0110, "R9"); step(1'b1, 3'b111, 1'b0, 1'b1, 4'hF, 9, "R9");
    step(1'b1, 3'b000, 1'b1, 1'b1, 4'hF, 9, "R9"); rd(9, "R9"); idle(4, "R9");
    for (int k = 0; k < 400; k++) begin
      int r = $urandom_range(0, 9);
      if (r < 4) rd($urandom_range(0, 3), "R8");
      else if (r < 7) wr($urandom_range(0, 3), 4'($urandom), "R6");
      else if (r == 7) step(1'b1, 3'($urandom), 1'($urandom), 1'($urandom), 4'($urandom), 1, "R9");
      else step(1'b0, 3'($urandom_range(0, 6)), 1'($urandom), 1'($urandom), 4'h0, 2, "R2");
    end
    idle(4, "R10");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    for (int a = 0; a < DEPTH; a++) wr(a, 4'h0, "R5");
    idle(3, "R5");
    for (int a = 0; a < DEPTH; a++) rd(a, "R5");
    idle(3, "R3");
    run_mode("R3");
    ft_mode = 1'b1;
    idle(3, "R4");
    for (int a = 0; a < DEPTH; a++) rd(a, "R4");
    run_mode("R4");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #1ms;
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule